// File: doc/BRIEF.md
# Interrupt Select and Status-Word Swap Sequencer

This block sits beside an instruction pipeline. On each instruction-boundary strobe it looks at the interruption sources that are waiting, picks one, and carries out the status-word exchange through a single 64-bit memory port. The sources are program exceptions, supervisor calls, a stack of queued external events, a time-of-day comparator event and a CPU-timer event. The exchange has three steps. First it writes the interruption parameters to fixed slots relative to a prefix base. Then it writes the old status word, with the live condition code folded in, and the old address. Last it reads the new status word and new address from the slot that belongs to the chosen source.

All sources arrive as single-cycle event pulses. The block latches each one as a pending flag and clears it when that source is selected. External sources wait while the external-mask bit of the current status word is clear. The loaded word is presented with a one-cycle valid pulse and a one-hot acknowledge that names the serviced source. The loaded word also sets the condition code and the halted state. A hard-interrupt request line stays high until a delivery finishes with nothing left pending.

Top module: `isw_swap_seq`

## Requirements
- R1: After reset, mem_req, new_valid, ack_src, halted and irq_req are all 0.
- R2: A selection happens only when bound is high and the sequencer is idle. The order of precedence is: program exception first, then supervisor call, then the external class.
- R3: External sources are considered only while cur_mask bit 56 is 1. While that bit is 0 they stay pending, and bound causes no memory request and no new_valid.
- R4: Within the external class, a queued event comes first, then the time-of-day event (code 0x1004, both parameters zero), then the CPU-timer event (code 0x1005, both parameters zero).
- R5: Queued external events form a stack of QDEPTH entries that is served last-in first-out. A push made while the stack is full is discarded.
- R6: One delivery issues these accesses in order: parameter word(s), old mask, old address, read of new mask, read of new address. Offsets from prefix are: supervisor call 0x00, 0x10/0x18, 0x50/0x58; program 0x08, 0x20/0x28, 0x60/0x68; external 0x30 and 0x38, 0x40/0x48, 0x70/0x78. Read data returns one cycle after the request.
- R7: The stored old mask is cur_mask with bits 14:13 replaced by cur_cc. new_cc equals bits 14:13 of the loaded mask.
- R8: A supervisor call stores {32'h0, 16-bit length, 16-bit code}. Its old address is cur_addr plus the length.
- R9: A program exception stores {32'h0, 16-bit length code, 16-bit code}. The kind field sets the address step: kind 0 stores the length and leaves the address unchanged; kind 1 stores the length and adds it to the address; kind 2 stores twice the length and adds that to the address; kind 3 behaves as kind 0.
- R10: An external delivery stores word {cpu_num OR 0x0D00 in bits 63:48, code in 47:32, 32-bit parameter in 31:0} and then the 64-bit parameter.
- R11: halted equals bit 49 of the most recently loaded mask.
- R12: irq_req rises the cycle after any event input. It falls only together with a new_valid pulse, and only when no source (masked externals included) is still pending.
- R13: new_valid and ack_src pulse for one cycle, the cycle after the new-address read returns. The ack_src bits are: bit 0 program, bit 1 supervisor call, bit 2 queued external, bit 3 time-of-day, bit 4 CPU timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bound | input | 1 | Instruction-boundary strobe |
| cur_mask | input | 64 | Current status-word mask |
| cur_addr | input | 64 | Current instruction address |
| cur_cc | input | 2 | Live condition code |
| prefix | input | AW | Base of the low-memory slot area |
| cpu_num | input | 16 | CPU address stored with external events |
| pgm_evt | input | 1 | Program exception event |
| pgm_code | input | 16 | Program interruption code |
| pgm_len | input | LEN_W | Instruction length in bytes |
| pgm_kind | input | 2 | Address-step kind |
| svc_evt | input | 1 | Supervisor call event |
| svc_code | input | 16 | Call code |
| svc_len | input | LEN_W | Call instruction length |
| tod_evt | input | 1 | Time-of-day comparator event |
| cpt_evt | input | 1 | CPU-timer event |
| ext_push | input | 1 | Push a queued external event |
| ext_code | input | 16 | Queued event code |
| ext_p32 | input | 32 | Queued event 32-bit parameter |
| ext_p64 | input | 64 | Queued event 64-bit parameter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after request |
| new_valid | output | 1 | New status word loaded |
| new_mask | output | 64 | Loaded mask |
| new_addr | output | 64 | Loaded address |
| new_cc | output | 2 | Condition code from loaded mask |
| halted | output | 1 | Wait state entered |
| ack_src | output | 5 | One-hot serviced source |
| irq_req | output | 1 | Hard-interrupt request |

## Verification
The hardest situation to reach is the overfull external stack draining behind masked timer events. Every queued entry, the time-of-day event and the CPU-timer event must all be pending at once, with the request line held high across several deliveries. The stimulus clears the external mask and pushes one entry more than the stack holds. It also fires both timer events and shows that a boundary then does nothing. Only after that is the mask set, and the bench walks the deliveries one boundary at a time. It checks the last-in first-out codes, the timer codes and the request line after each delivery, and finally checks that no phantom fifth entry appears.

// File: rtl/isw_pkg.sv
`timescale 1ns/1ps
package isw_pkg;
  localparam int CC_LSB       = 13;
  localparam int EXT_MASK_BIT = 56;
  localparam int WAIT_BIT     = 49;
  localparam logic [15:0] TOD_CODE     = 16'h1004;
  localparam logic [15:0] CPT_CODE     = 16'h1005;
  localparam logic [15:0] CPU_ADDR_TAG = 16'h0D00;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PGM, SRC_SVC, SRC_EXTQ, SRC_TOD, SRC_CPT
  } src_e;

  typedef struct packed {
    logic [7:0] parm0;
    logic [7:0] parm1;
    logic [7:0] old_mask;
    logic [7:0] new_mask;
  } slot_t;

  function automatic slot_t slot_of(src_e s);
    case (s)
      SRC_PGM: slot_of = '{8'h08, 8'h08, 8'h20, 8'h60};
      SRC_SVC: slot_of = '{8'h00, 8'h00, 8'h10, 8'h50};
      default: slot_of = '{8'h30, 8'h38, 8'h40, 8'h70};
    endcase
  endfunction

  function automatic logic is_ext(src_e s);
    is_ext = (s == SRC_EXTQ) || (s == SRC_TOD) || (s == SRC_CPT);
  endfunction

  function automatic logic [4:0] src_bit(src_e s);
    case (s)
      SRC_PGM:  src_bit = 5'b00001;
      SRC_SVC:  src_bit = 5'b00010;
      SRC_EXTQ: src_bit = 5'b00100;
      SRC_TOD:  src_bit = 5'b01000;
      SRC_CPT:  src_bit = 5'b10000;
      default:  src_bit = 5'b00000;
    endcase
  endfunction

  // Old mask with the live condition code folded into bits 14:13.
  function automatic logic [63:0] fold_cc(logic [63:0] m, logic [1:0] cc);
    fold_cc = m;
    fold_cc[CC_LSB +: 2] = cc;
  endfunction

  // Length code stored for a program exception of the given kind.
  function automatic logic [15:0] pgm_ilc(logic [7:0] len, logic [1:0] kind);
    pgm_ilc = (kind == 2'd2) ? {7'd0, len, 1'b0} : {8'd0, len};
  endfunction

  // Address step applied before a program exception's old address is stored.
  function automatic logic [63:0] pgm_step(logic [7:0] len, logic [1:0] kind);
    case (kind)
      2'd1:    pgm_step = {56'd0, len};
      2'd2:    pgm_step = {55'd0, len, 1'b0};
      default: pgm_step = 64'd0;
    endcase
  endfunction
endpackage

// File: rtl/isw_ext_stack.sv
`timescale 1ns/1ps
module isw_ext_stack #(
  parameter int DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [15:0]                      push_code,
  input  logic [31:0]                      push_p32,
  input  logic [63:0]                      push_p64,
  input  logic                             pop,
  output logic                             nonempty,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic [15:0]                      top_code,
  output logic [31:0]                      top_p32,
  output logic [63:0]                      top_p64
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [15:0] code_m [DEPTH];
  logic [31:0] p32_m  [DEPTH];
  logic [63:0] p64_m  [DEPTH];
  logic pop_ok, push_ok;
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign nonempty = (count != '0);
  assign pop_ok   = pop && nonempty;
  assign push_ok  = push && ((count < CNT_W'(DEPTH)) || pop_ok);
  assign top_idx  = IDX_W'(count - 1'b1);
  assign wr_idx   = pop_ok ? top_idx : IDX_W'(count);
  assign top_code = code_m[top_idx];
  assign top_p32  = p32_m[top_idx];
  assign top_p64  = p64_m[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push_ok && !pop_ok) begin
      count <= count + 1'b1;
    end else if (pop_ok && !push_ok) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      code_m[wr_idx] <= push_code;
      p32_m[wr_idx]  <= push_p32;
      p64_m[wr_idx]  <= push_p64;
    end
  end
endmodule

// File: rtl/isw_arbiter.sv
`timescale 1ns/1ps
module isw_arbiter
  import isw_pkg::*;
(
  input  logic pgm,
  input  logic svc,
  input  logic extq,
  input  logic tod,
  input  logic cpt,
  input  logic ext_en,
  output src_e pick
);
  always_comb begin
    if (pgm)                pick = SRC_PGM;
    else if (svc)           pick = SRC_SVC;
    else if (ext_en && extq) pick = SRC_EXTQ;
    else if (ext_en && tod) pick = SRC_TOD;
    else if (ext_en && cpt) pick = SRC_CPT;
    else                    pick = SRC_NONE;
  end
endmodule

// File: rtl/isw_swap_seq.sv
`timescale 1ns/1ps
module isw_swap_seq
  import isw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QDEPTH = 4,
  parameter int LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bound,
  input  logic [63:0]      cur_mask,
  input  logic [63:0]      cur_addr,
  input  logic [1:0]       cur_cc,
  input  logic [AW-1:0]    prefix,
  input  logic [15:0]      cpu_num,
  input  logic             pgm_evt,
  input  logic [15:0]      pgm_code,
  input  logic [LEN_W-1:0] pgm_len,
  input  logic [1:0]       pgm_kind,
  input  logic             svc_evt,
  input  logic [15:0]      svc_code,
  input  logic [LEN_W-1:0] svc_len,
  input  logic             tod_evt,
  input  logic             cpt_evt,
  input  logic             ext_push,
  input  logic [15:0]      ext_code,
  input  logic [31:0]      ext_p32,
  input  logic [63:0]      ext_p64,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic [63:0]      mem_rdata,
  output logic             new_valid,
  output logic [63:0]      new_mask,
  output logic [63:0]      new_addr,
  output logic [1:0]       new_cc,
  output logic             halted,
  output logic [4:0]       ack_src,
  output logic             irq_req
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PARM0, S_PARM1, S_OLDM, S_OLDA, S_RDM, S_RDA, S_DONE
  } st_e;

  st_e  state, state_nxt;
  src_e src_q, pick;
  logic pgm_f, svc_f, tod_f, cpt_f;
  logic [15:0]      pgm_code_q, svc_code_q;
  logic [LEN_W-1:0] pgm_len_q, svc_len_q;
  logic [1:0]       pgm_kind_q;
  logic [63:0]      pw0_q, pw1_q, om_q, oa_q, nm_q;
  logic             q_nonempty;
  logic [CNT_W-1:0] q_cnt;
  logic [15:0]      q_code;
  logic [31:0]      q_p32;
  logic [63:0]      q_p64;
  logic [15:0]      ext_tag;
  slot_t            slot;
  logic [7:0]       off;
  // Named events for the checker.
  logic take, pop, done, ext_taken, ext_en, any_flag, any_evt;

  assign ext_en    = cur_mask[EXT_MASK_BIT];
  assign take      = (state == S_IDLE) && bound && (pick != SRC_NONE);
  assign ext_taken = take && is_ext(pick);
  assign pop       = take && (pick == SRC_EXTQ);
  assign done      = (state == S_DONE);
  assign any_flag  = pgm_f | svc_f | tod_f | cpt_f | q_nonempty;
  assign any_evt   = pgm_evt | svc_evt | tod_evt | cpt_evt | ext_push;
  assign ext_tag   = cpu_num | CPU_ADDR_TAG;

  isw_ext_stack #(.DEPTH(QDEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ext_push), .push_code(ext_code),
    .push_p32(ext_p32), .push_p64(ext_p64), .pop(pop), .nonempty(q_nonempty),
    .count(q_cnt), .top_code(q_code), .top_p32(q_p32), .top_p64(q_p64)
  );

  isw_arbiter u_arb (
    .pgm(pgm_f), .svc(svc_f), .extq(q_nonempty), .tod(tod_f), .cpt(cpt_f),
    .ext_en(ext_en), .pick(pick)
  );

  // Pending flags: a new event wins over the clear of the same source.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_f <= 1'b0; svc_f <= 1'b0; tod_f <= 1'b0; cpt_f <= 1'b0;
    end else begin
      pgm_f <= pgm_evt | (pgm_f & ~(take && pick == SRC_PGM));
      svc_f <= svc_evt | (svc_f & ~(take && pick == SRC_SVC));
      tod_f <= tod_evt | (tod_f & ~(take && pick == SRC_TOD));
      cpt_f <= cpt_evt | (cpt_f & ~(take && pick == SRC_CPT));
    end
  end

  always_ff @(posedge clk) begin
    if (pgm_evt) begin
      pgm_code_q <= pgm_code; pgm_len_q <= pgm_len; pgm_kind_q <= pgm_kind;
    end
    if (svc_evt) begin
      svc_code_q <= svc_code; svc_len_q <= svc_len;
    end
  end

  // Snapshot of everything the delivery writes, taken at selection.
  always_ff @(posedge clk) begin
    if (take) begin
      src_q <= pick;
      om_q  <= fold_cc(cur_mask, cur_cc);
      pw1_q <= 64'd0;
      oa_q  <= cur_addr;
      case (pick)
        SRC_PGM: begin
          pw0_q <= {32'd0, pgm_ilc(8'(pgm_len_q), pgm_kind_q), pgm_code_q};
          oa_q  <= cur_addr + pgm_step(8'(pgm_len_q), pgm_kind_q);
        end
        SRC_SVC: begin
          pw0_q <= {32'd0, 16'(svc_len_q), svc_code_q};
          oa_q  <= cur_addr + 64'(svc_len_q);
        end
        SRC_EXTQ: begin
          pw0_q <= {ext_tag, q_code, q_p32};
          pw1_q <= q_p64;
        end
        SRC_TOD: pw0_q <= {ext_tag, TOD_CODE, 32'd0};
        default: pw0_q <= {ext_tag, CPT_CODE, 32'd0};
      endcase
    end
    if (state == S_RDA) nm_q <= mem_rdata;
  end

  always_comb begin
    state_nxt = state;
    case (state)
      S_IDLE:  if (take) state_nxt = S_PARM0;
      S_PARM0: state_nxt = is_ext(src_q) ? S_PARM1 : S_OLDM;
      S_PARM1: state_nxt = S_OLDM;
      S_OLDM:  state_nxt = S_OLDA;
      S_OLDA:  state_nxt = S_RDM;
      S_RDM:   state_nxt = S_RDA;
      S_RDA:   state_nxt = S_DONE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nxt;
  end

  always_comb begin
    slot      = slot_of(src_q);
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    off       = 8'd0;
    mem_wdata = 64'd0;
    case (state)
      S_PARM0: begin mem_req = 1'b1; mem_we = 1'b1; off = slot.parm0;          mem_wdata = pw0_q; end
      S_PARM1: begin mem_req = 1'b1; mem_we = 1'b1; off = slot.parm1;          mem_wdata = pw1_q; end
      S_OLDM:  begin mem_req = 1'b1; mem_we = 1'b1; off = slot.old_mask;       mem_wdata = om_q;  end
      S_OLDA:  begin mem_req = 1'b1; mem_we = 1'b1; off = slot.old_mask + 8'd8; mem_wdata = oa_q; end
      S_RDM:   begin mem_req = 1'b1; off = slot.new_mask; end
      S_RDA:   begin mem_req = 1'b1; off = slot.new_mask + 8'd8; end
      default: ;
    endcase
  end

  assign mem_addr = prefix + {{(AW-8){1'b0}}, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_valid <= 1'b0; ack_src <= 5'd0; halted <= 1'b0; irq_req <= 1'b0;
      new_mask <= 64'd0; new_addr <= 64'd0; new_cc <= 2'd0;
    end else begin
      new_valid <= done;
      ack_src   <= done ? src_bit(src_q) : 5'd0;
      irq_req   <= (irq_req & ~done) | any_flag | any_evt;
      if (done) begin
        new_mask <= nm_q;
        new_addr <= mem_rdata;
        new_cc   <= nm_q[CC_LSB +: 2];
        halted   <= nm_q[WAIT_BIT];
      end
    end
  end
endmodule

// File: rtl/isw_swap_chk.sv
`timescale 1ns/1ps
module isw_swap_chk
  import isw_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [63:0]                   cur_mask,
  input logic                          ext_taken,
  input logic                          pgm_f,
  input logic                          svc_f,
  input logic                          pop,
  input logic [$clog2(QDEPTH+1)-1:0]   q_cnt,
  input logic                          mem_req,
  input logic                          mem_we,
  input logic                          new_valid,
  input logic [63:0]                   new_mask,
  input logic [1:0]                    new_cc,
  input logic                          halted,
  input logic [4:0]                    ack_src,
  input logic                          irq_req
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  AST_EXT_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_taken |-> cur_mask[EXT_MASK_BIT]); // R3
  AST_EXT_BEHIND_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_taken |-> (!pgm_f && !svc_f)); // R2
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(QDEPTH)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (q_cnt != '0)); // R5
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !(mem_req && mem_we)); // R6
  AST_CC_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
    new_valid |-> (new_cc == new_mask[CC_LSB +: 2])); // R7
  AST_HALT_TRACKS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    new_valid |-> (halted == new_mask[WAIT_BIT])); // R11
  AST_IRQ_DROP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> new_valid); // R12
  AST_ACK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (new_valid || ack_src != 5'd0) |-> (new_valid && $countones(ack_src) == 1)); // R13
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    new_valid |=> !new_valid); // R13
endmodule

bind isw_swap_seq isw_swap_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_mask(cur_mask), .ext_taken(ext_taken),
  .pgm_f(pgm_f), .svc_f(svc_f), .pop(pop), .q_cnt(q_cnt), .mem_req(mem_req),
  .mem_we(mem_we), .new_valid(new_valid), .new_mask(new_mask), .new_cc(new_cc),
  .halted(halted), .ack_src(ack_src), .irq_req(irq_req)
);

// File: tb/isw_swap_seq_test.sv
`timescale 1ns/1ps
module isw_swap_seq_test;
  localparam int AW = 32;
  localparam int QD = 4;
  localparam logic [63:0] EXT_ON = 64'h0100_0000_0000_0000;
  localparam logic [63:0] WAITB  = 64'h0002_0000_0000_0000;
  localparam logic [AW-1:0] PFX  = 32'h0000_2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bound, pgm_evt, svc_evt, tod_evt, cpt_evt, ext_push;
  logic [63:0] cur_mask, cur_addr, ext_p64, mem_rdata;
  logic [1:0]  cur_cc, pgm_kind;
  logic [AW-1:0] prefix;
  logic [15:0] cpu_num, pgm_code, svc_code, ext_code;
  logic [3:0]  pgm_len, svc_len;
  logic [31:0] ext_p32;
  logic mem_req, mem_we, new_valid, halted, irq_req;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, new_mask, new_addr;
  logic [1:0]  new_cc;
  logic [4:0]  ack_src;

  int nchk = 0;
  int nerr = 0;

  isw_swap_seq #(.AW(AW), .QDEPTH(QD), .LEN_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bound(bound), .cur_mask(cur_mask), .cur_addr(cur_addr),
    .cur_cc(cur_cc), .prefix(prefix), .cpu_num(cpu_num), .pgm_evt(pgm_evt),
    .pgm_code(pgm_code), .pgm_len(pgm_len), .pgm_kind(pgm_kind), .svc_evt(svc_evt),
    .svc_code(svc_code), .svc_len(svc_len), .tod_evt(tod_evt), .cpt_evt(cpt_evt),
    .ext_push(ext_push), .ext_code(ext_code), .ext_p32(ext_p32), .ext_p64(ext_p64),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .new_valid(new_valid), .new_mask(new_mask),
    .new_addr(new_addr), .new_cc(new_cc), .halted(halted), .ack_src(ack_src),
    .irq_req(irq_req)
  );

  // Memory model: read data one cycle after the request.
  logic [63:0] mem [64];
  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:3]];

  typedef struct packed { logic [AW-1:0] a; logic [63:0] d; } wr_t;
  typedef struct packed {
    logic [4:0] ack; logic [63:0] m; logic [63:0] a; logic h; logic [1:0] cc;
  } res_t;
  wr_t   exp_wr[$];
  res_t  exp_res[$];
  string exp_tag[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as the design produces results.
  always @(negedge clk) begin : monitor
    wr_t e; res_t r; string t;
    if (rst_n) begin
      if (mem_req && mem_we) begin
        if (exp_wr.size() == 0) begin
          check(1'b0, "R6 unexpected write", {32'd0, mem_addr}, 64'd0);
        end else begin
          e = exp_wr.pop_front();
          check(mem_addr === e.a, "R6 write address", {32'd0, mem_addr}, {32'd0, e.a});
          check(mem_wdata === e.d, "R6 write data", mem_wdata, e.d);
        end
      end
      if (new_valid) begin
        if (exp_res.size() == 0) begin
          check(1'b0, "R13 unexpected load", {59'd0, ack_src}, 64'd0);
        end else begin
          r = exp_res.pop_front(); t = exp_tag.pop_front();
          check(ack_src === r.ack, {t, " R13 ack source"}, {59'd0, ack_src}, {59'd0, r.ack});
          check(new_mask === r.m, {t, " new mask"}, new_mask, r.m);
          check(new_addr === r.a, {t, " new address"}, new_addr, r.a);
          check(new_cc === r.cc, {t, " R7 new cc"}, {62'd0, new_cc}, {62'd0, r.cc});
          check(halted === r.h, {t, " R11 halted"}, {63'd0, halted}, {63'd0, r.h});
        end
      end
    end
  end

  // Driver: push the expected accesses and result of one delivery.
  task automatic expect_swap(input int src, input logic [63:0] pw0, input logic [63:0] pw1,
                             input logic [63:0] oa, input logic [63:0] nm,
                             input logic [63:0] na, input string tag);
    logic [7:0] p0, om_off, nm_off;
    logic [63:0] om;
    case (src)
      1: begin p0 = 8'h08; om_off = 8'h20; nm_off = 8'h60; end
      2: begin p0 = 8'h00; om_off = 8'h10; nm_off = 8'h50; end
      default: begin p0 = 8'h30; om_off = 8'h40; nm_off = 8'h70; end
    endcase
    om = (cur_mask & ~(64'h3 << 13)) | (64'(cur_cc) << 13);
    exp_wr.push_back('{PFX + AW'(p0), pw0});
    if (src >= 3) exp_wr.push_back('{PFX + AW'(8'h38), pw1});
    exp_wr.push_back('{PFX + AW'(om_off), om});
    exp_wr.push_back('{PFX + AW'(om_off + 8'd8), oa});
    mem[nm_off >> 3] = nm;
    mem[(nm_off + 8'd8) >> 3] = na;
    exp_res.push_back('{5'(1 << (src - 1)), nm, na, nm[49], nm[14:13]});
    exp_tag.push_back(tag);
  endtask

  task automatic boundary(input string tag);
    bit seen = 1'b0;
    @(negedge clk) bound = 1'b1;
    @(negedge clk) bound = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (new_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check(seen, {tag, " R2 delivery completes"}, {63'd0, seen}, 64'd1);
  endtask

  task automatic idle_check(input string tag);
    bit quiet = 1'b1;
    @(negedge clk) bound = 1'b1;
    @(negedge clk) bound = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (mem_req || new_valid) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, {tag, " no delivery"}, {63'd0, quiet}, 64'd1);
  endtask

  task automatic pulse_svc(input logic [15:0] code, input logic [3:0] len);
    @(negedge clk) begin svc_evt = 1'b1; svc_code = code; svc_len = len; end
    @(negedge clk) svc_evt = 1'b0;
  endtask

  task automatic pulse_pgm(input logic [15:0] code, input logic [3:0] len, input logic [1:0] kind);
    @(negedge clk) begin pgm_evt = 1'b1; pgm_code = code; pgm_len = len; pgm_kind = kind; end
    @(negedge clk) pgm_evt = 1'b0;
  endtask

  task automatic push_ext(input int i);
    @(negedge clk) begin
      ext_push = 1'b1; ext_code = 16'h2400 + 16'(i);
      ext_p32 = 32'hA000_0000 + 32'(i); ext_p64 = {32'hB000_0000, 32'(i)};
    end
    @(negedge clk) ext_push = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL R13 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : stim
    logic [63:0] ladd;
    for (int i = 0; i < 64; i++) mem[i] = 64'd0;
    rst_n = 1'b0; bound = 1'b0; pgm_evt = 1'b0; svc_evt = 1'b0; tod_evt = 1'b0;
    cpt_evt = 1'b0; ext_push = 1'b0; cur_mask = 64'd0; cur_addr = 64'd0; cur_cc = 2'd0;
    prefix = PFX; cpu_num = 16'h0003; pgm_code = 16'd0; pgm_len = 4'd0; pgm_kind = 2'd0;
    svc_code = 16'd0; svc_len = 4'd0; ext_code = 16'd0; ext_p32 = 32'd0; ext_p64 = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!mem_req && !new_valid && ack_src == 5'd0, "R1 idle outputs",
          {58'd0, mem_req, new_valid, ack_src}, 64'd0);
    check(!halted && !irq_req, "R1 halted and irq", {62'd0, halted, irq_req}, 64'd0);

    // R8, R7: supervisor call, cc folded into the old mask
    cur_mask = 64'h0000_0001_0000_6000; cur_cc = 2'b01; cur_addr = 64'h0010_0000;
    pulse_svc(16'h0042, 4'd4);
    check(irq_req === 1'b1, "R12 irq rises", {63'd0, irq_req}, 64'd1);
    expect_swap(2, {32'd0, 16'd4, 16'h0042}, 64'd0, 64'h0010_0004,
                64'h0000_0000_0000_4000, 64'h5000, "R8");
    boundary("R8");
    check(irq_req === 1'b0, "R12 irq drops when nothing left", {63'd0, irq_req}, 64'd0);

    // R9: program exception kinds
    for (int k = 0; k < 4; k++) begin
      cur_addr = 64'h0020_0000 + 64'(k * 64'h100); cur_cc = 2'(k);
      pulse_pgm(16'h0011 + 16'(k), 4'd6, 2'(k));
      ladd = (k == 1) ? cur_addr + 6 : (k == 2) ? cur_addr + 12 : cur_addr;
      expect_swap(1, {32'd0, (k == 2) ? 16'd12 : 16'd6, 16'h0011 + 16'(k)}, 64'd0, ladd,
                  64'h0000_0000_0000_2000 | 64'(k), 64'h6000 + 64'(k), "R9");
      boundary("R9");
    end

    // R2: program, then supervisor call, then time-of-day
    cur_mask = EXT_ON; cur_cc = 2'b10; cur_addr = 64'h0030_0000;
    pulse_tod_svc_pgm: begin
      @(negedge clk) begin
        tod_evt = 1'b1; svc_evt = 1'b1; svc_code = 16'h0007; svc_len = 4'd2;
        pgm_evt = 1'b1; pgm_code = 16'h0004; pgm_len = 4'd4; pgm_kind = 2'd1;
      end
      @(negedge clk) begin tod_evt = 1'b0; svc_evt = 1'b0; pgm_evt = 1'b0; end
    end
    expect_swap(1, {32'd0, 16'd4, 16'h0004}, 64'd0, 64'h0030_0004, EXT_ON, 64'h7100, "R2 pgm first");
    boundary("R2");
    check(irq_req === 1'b1, "R12 irq held with sources left", {63'd0, irq_req}, 64'd1);
    expect_swap(2, {32'd0, 16'd2, 16'h0007}, 64'd0, 64'h0030_0002, EXT_ON, 64'h7200, "R2 svc second");
    boundary("R2");
    expect_swap(4, {16'h0D03, 16'h1004, 32'd0}, 64'd0, 64'h0030_0000, EXT_ON, 64'h7300, "R4 tod");
    boundary("R4");

    // R3, R5: masked externals stay pending; overfull stack
    cur_mask = 64'd0; cur_cc = 2'b00; cur_addr = 64'h0040_0000;
    @(negedge clk);
    check(irq_req === 1'b0, "R12 irq low before events", {63'd0, irq_req}, 64'd0);
    @(negedge clk) begin tod_evt = 1'b1; cpt_evt = 1'b1; end
    @(negedge clk) begin tod_evt = 1'b0; cpt_evt = 1'b0; end
    for (int i = 1; i <= QD + 1; i++) push_ext(i);
    idle_check("R3 masked");
    check(irq_req === 1'b1, "R3 irq stays with masked sources", {63'd0, irq_req}, 64'd1);

    // R4, R5, R10: unmask and drain in order
    cur_mask = EXT_ON | 64'h0000_0000_0000_0400; cur_cc = 2'b11;
    for (int i = QD; i >= 1; i--) begin
      expect_swap(3, {16'h0D03, 16'h2400 + 16'(i), 32'hA000_0000 + 32'(i)},
                  {32'hB000_0000, 32'(i)}, 64'h0040_0000, EXT_ON, 64'h8000 + 64'(i), "R5 R10 queued");
      boundary("R5");
      check(irq_req === 1'b1, "R12 irq held while queue drains", {63'd0, irq_req}, 64'd1);
    end
    expect_swap(4, {16'h0D03, 16'h1004, 32'd0}, 64'd0, 64'h0040_0000, EXT_ON, 64'h9000, "R4 tod");
    boundary("R4");
    expect_swap(5, {16'h0D03, 16'h1005, 32'd0}, 64'd0, 64'h0040_0000, EXT_ON, 64'h9100, "R4 cpt");
    boundary("R4");
    check(irq_req === 1'b0, "R12 irq drops after last source", {63'd0, irq_req}, 64'd0);
    idle_check("R5 discarded push");

    // R11: wait bit halts, next load without it resumes
    cur_mask = 64'd0; cur_cc = 2'b00; cur_addr = 64'h0050_0000;
    pulse_svc(16'h0009, 4'd2);
    expect_swap(2, {32'd0, 16'd2, 16'h0009}, 64'd0, 64'h0050_0002, WAITB | EXT_ON, 64'hA000, "R11 wait");
    boundary("R11");
    pulse_svc(16'h000A, 4'd4);
    expect_swap(2, {32'd0, 16'd4, 16'h000A}, 64'd0, 64'h0050_0004, 64'h0000_0000_0000_6000, 64'hA100, "R11 resume");
    boundary("R11");

    repeat (4) @(negedge clk);
    check(exp_wr.size() == 0 && exp_res.size() == 0, "R6 scoreboard drained",
          64'(exp_wr.size() + exp_res.size()), 64'd0);
    summary();
    $finish;
  end
endmodule